// File: doc/BRIEF.md
# Vector register interleave layout mapper

This block moves one vector register's worth of bytes between memory byte order and the byte layout held in the register file. It sits on the data path between a load/store unit and the register file. A load turns a memory-ordered word into register layout. A store turns register contents back into a memory-ordered word. A 2-bit mode chooses the layout. The register is split into chunks of SLEN bits. Mode 0 deals whole elements round-robin across those chunks. Mode 3 keeps memory order unchanged. Modes 1 and 2 pack memory-ordered bytes into only the lower or only the upper half of every chunk.

The register width VLEN and the chunk width SLEN are parameters. SLEN must be at least 16, a power of two, and must divide VLEN. The element width (SEW) is chosen per transfer from 8, 16, 32 or 64 bits. In the half-chunk modes, a load fills the unused half of each chunk in one of two ways: it copies the old register contents, or it writes all ones. A store in those modes returns a half-width memory word. The result is registered and a new transfer may enter every cycle.

Top module: `vil_layout_mapper`

## Requirements
- R1: While reset is held and in the first cycle after it, out_valid, out_data and out_err are all zero.
- R2: out_valid rises exactly one cycle after each cycle in which in_valid is high, and falls one cycle after a cycle with in_valid low. Inputs presented on consecutive cycles each give one result on consecutive cycles.
- R3: With in_mode = 3 (flat), out_data equals in_data for both directions (in_dir 0 = load, 1 = store).
- R4: With in_mode = 0 on a load, element i has a size of E = 1 << in_sew bytes (in_sew 0/1/2/3 = 8/16/32/64 bits). Memory bytes i*E+b go to register byte (i mod NCH)*CB + (i div NCH)*E + b. Here CB = SLEN/8 and NCH = VLEN/SLEN.
- R5: With in_mode = 0 on a store, the mapping of R4 is inverted, so register byte (i mod NCH)*CB + (i div NCH)*E + b goes to memory byte i*E+b.
- R6: With in_mode = 1 on a load, memory byte k (for k < VLEN/16) goes to register byte (k div H)*CB + (k mod H). Here H = CB/2, so only the lower half of each chunk is filled.
- R7: With in_mode = 2 on a load, memory byte k goes to register byte (k div H)*CB + H + (k mod H), so only the upper half of each chunk is filled.
- R8: In modes 1 and 2 on a load, each byte of the unfilled half takes a value set by in_policy. With in_policy = 0 it takes the matching byte of in_old. With in_policy = 1 it takes 8'hFF.
- R9: In modes 1 and 2 on a store, memory byte k (k < VLEN/16) comes from the register byte named in R6 or R7, and the upper VLEN/2 bits of out_data are zero.
- R10: When 8 << in_sew exceeds SLEN, the transfer behaves as mode 3 whatever in_mode is, and out_err is 1 with the result. Otherwise out_err is 0.
- R11: When SLEN equals VLEN, mode 0 and mode 3 give the same result for every SEW and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transfer strobe |
| in_dir | input | 1 | 0 = load (memory to register), 1 = store (register to memory) |
| in_mode | input | 2 | 0 round-robin, 1 lower half, 2 upper half, 3 flat |
| in_sew | input | 2 | Element width code: 8 << in_sew bits |
| in_policy | input | 1 | Gap fill on half-mode loads: 0 keep old byte, 1 all ones |
| in_data | input | VLEN | Memory word on a load, register word on a store |
| in_old | input | VLEN | Previous destination register contents |
| out_valid | output | 1 | Result valid |
| out_data | output | VLEN | Remapped word |
| out_err | output | 1 | SEW wider than SLEN; flat layout was used |

## Verification
The bench targets element sizes that divide a chunk into one, two and four slots in round-robin mode. An index formula with operands swapped, or a divide used in place of a modulo, would scatter bytes into the wrong chunk. It runs each half-chunk mode with both gap policies: a design that confused the halves would overwrite live data, and one that ignored the policy would leak old bytes or constants. Half-mode stores catch a gather that reads the wrong half or leaves junk above VLEN/2. A 64-bit element on 32-bit chunks and a second instance with SLEN equal to VLEN catch an error path that still interleaves, and a round-robin mode that does not collapse to flat order.

// File: rtl/vil_pkg.sv
package vil_pkg;

  typedef enum logic [1:0] {
    MODE_RR   = 2'd0,
    MODE_LO   = 2'd1,
    MODE_HI   = 2'd2,
    MODE_FLAT = 2'd3
  } vil_mode_e;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_OLD  = 2'd1,
    SRC_ONES = 2'd2,
    SRC_ZERO = 2'd3
  } vil_src_e;

  typedef struct packed {
    vil_src_e    kind;
    logic [15:0] idx;
  } vil_sel_t;

  // element width in bits for a SEW code
  function automatic int unsigned sew_bits(logic [1:0] code);
    return 32'd8 << code;
  endfunction

  // Where output byte ob comes from, for one layout setting.
  // cb_lg = log2(chunk bytes), nch_lg = log2(chunk count), nb = bytes per word
  function automatic vil_sel_t byte_source(int unsigned ob, vil_mode_e mode,
                                           logic [1:0] sew_lg, logic is_store,
                                           logic agnostic, int unsigned nb,
                                           int unsigned cb_lg, int unsigned nch_lg);
    vil_sel_t    r;
    int unsigned cb, hb, c, o, s, b, i, src;
    cb  = 32'd1 << cb_lg;
    hb  = cb >> 1;
    src = ob;
    r.kind = SRC_DATA;
    case (mode)
      MODE_RR: begin
        if (!is_store) begin
          c   = ob >> cb_lg;
          o   = ob & (cb - 1);
          s   = o >> sew_lg;
          b   = o & ((32'd1 << sew_lg) - 1);
          i   = (s << nch_lg) + c;
          src = (i << sew_lg) + b;
        end else begin
          i   = ob >> sew_lg;
          b   = ob & ((32'd1 << sew_lg) - 1);
          c   = i & ((32'd1 << nch_lg) - 1);
          s   = i >> nch_lg;
          src = (c << cb_lg) + (s << sew_lg) + b;
        end
      end
      MODE_LO, MODE_HI: begin
        if (!is_store) begin
          c = ob >> cb_lg;
          o = ob & (cb - 1);
          if ((o >= hb) == (mode == MODE_HI)) begin
            src = c * hb + o - ((mode == MODE_HI) ? hb : 0);
          end else begin
            r.kind = agnostic ? SRC_ONES : SRC_OLD;
            src    = ob;
          end
        end else if (ob >= (nb >> 1)) begin
          r.kind = SRC_ZERO;
        end else begin
          c   = ob >> (cb_lg - 1);
          o   = ob & (hb - 1);
          src = (c << cb_lg) + o + ((mode == MODE_HI) ? hb : 0);
        end
      end
      default: src = ob;
    endcase
    r.idx = 16'(src);
    return r;
  endfunction

endpackage

// File: rtl/vil_mode_decode.sv
module vil_mode_decode
  import vil_pkg::*;
#(
  parameter int SLEN = 32
) (
  input  logic [1:0] sew,
  input  vil_mode_e  mode_in,
  output vil_mode_e  mode_eff,
  output logic       sew_err
);

  always_comb begin
    sew_err  = sew_bits(sew) > SLEN;
    mode_eff = sew_err ? MODE_FLAT : mode_in;
  end

endmodule

// File: rtl/vil_byte_router.sv
module vil_byte_router
  import vil_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input  logic [VLEN-1:0] data,
  input  logic [VLEN-1:0] old,
  input  vil_mode_e       mode,
  input  logic [1:0]      sew,
  input  logic            is_store,
  input  logic            agnostic,
  output logic [VLEN-1:0] result
);

  localparam int NB     = VLEN / 8;
  localparam int CB_LG  = $clog2(SLEN / 8);
  localparam int NCH_LG = $clog2(VLEN / SLEN);
  localparam int IDXW   = $clog2(NB);

  logic [7:0] data_b [NB];

  for (genvar g = 0; g < NB; g++) begin : g_unpack
    assign data_b[g] = data[8*g +: 8];
  end

  for (genvar g = 0; g < NB; g++) begin : g_byte
    vil_sel_t        sel;
    logic [IDXW-1:0] pick;
    always_comb begin
      sel  = byte_source(g, mode, sew, is_store, agnostic, NB, CB_LG, NCH_LG);
      pick = IDXW'(sel.idx);
      case (sel.kind)
        SRC_DATA: result[8*g +: 8] = data_b[pick];
        SRC_OLD:  result[8*g +: 8] = old[8*g +: 8];
        SRC_ONES: result[8*g +: 8] = 8'hFF;
        default:  result[8*g +: 8] = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/vil_layout_mapper.sv
module vil_layout_mapper
  import vil_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_dir,
  input  logic [1:0]      in_mode,
  input  logic [1:0]      in_sew,
  input  logic            in_policy,
  input  logic [VLEN-1:0] in_data,
  input  logic [VLEN-1:0] in_old,
  output logic            out_valid,
  output logic [VLEN-1:0] out_data,
  output logic            out_err
);

  // named internal events, observed by the bound checker
  vil_mode_e       mode_eff;
  logic            sew_err;
  logic [VLEN-1:0] mapped;

  vil_mode_decode #(.SLEN(SLEN)) u_decode (
    .sew      (in_sew),
    .mode_in  (vil_mode_e'(in_mode)),
    .mode_eff (mode_eff),
    .sew_err  (sew_err)
  );

  vil_byte_router #(.VLEN(VLEN), .SLEN(SLEN)) u_router (
    .data     (in_data),
    .old      (in_old),
    .mode     (mode_eff),
    .sew      (in_sew),
    .is_store (in_dir),
    .agnostic (in_policy),
    .result   (mapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= mapped;
        out_err  <= sew_err;
      end
    end
  end

endmodule

// File: rtl/vil_layout_mapper_chk.sv
module vil_layout_mapper_chk #(
  parameter int VLEN = 128,
  parameter int SLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_dir,
  input logic [1:0]      in_mode,
  input logic [1:0]      in_sew,
  input logic            in_policy,
  input logic [VLEN-1:0] in_data,
  input logic            sew_err,
  input logic            out_valid,
  input logic [VLEN-1:0] out_data,
  input logic            out_err
);

  localparam int NB = VLEN / 8;
  localparam int CB = SLEN / 8;

  function automatic logic [VLEN-1:0] half_bytes(bit upper);
    logic [VLEN-1:0] m;
    m = '0;
    for (int k = 0; k < NB; k++)
      if (((k % CB) >= CB / 2) == upper) m[8*k +: 8] = 8'hFF;
    return m;
  endfunction

  localparam logic [VLEN-1:0] UPPER_BYTES = half_bytes(1'b1);
  localparam logic [VLEN-1:0] LOWER_BYTES = half_bytes(1'b0);

  logic wide_sew;
  assign wide_sew = (32'd8 << in_sew) > SLEN;

  // R2: one result per accepted input, one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R3: flat mode copies the word unchanged
  a_r3_flat_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 2'd3) |=> out_data == $past(in_data));

  // R8: agnostic gap halves are all ones
  a_r8_lo_gap_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dir && in_mode == 2'd1 && in_policy && !wide_sew)
    |=> (out_data & UPPER_BYTES) == UPPER_BYTES);
  a_r8_hi_gap_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_dir && in_mode == 2'd2 && in_policy && !wide_sew)
    |=> (out_data & LOWER_BYTES) == LOWER_BYTES);

  // R9: half-mode store leaves the upper half of the word zero
  a_r9_half_store_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dir && (in_mode == 2'd1 || in_mode == 2'd2) && !wide_sew)
    |=> out_data[VLEN-1:VLEN/2] == '0);

  // R10: error flag tracks the decoded condition, and the data goes out flat
  a_r10_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_err == $past(wide_sew));
  a_r10_decode_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> sew_err == wide_sew);
  a_r10_err_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_sew) |=> out_data == $past(in_data));

endmodule

bind vil_layout_mapper vil_layout_mapper_chk #(.VLEN(VLEN), .SLEN(SLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_dir    (in_dir),
  .in_mode   (in_mode),
  .in_sew    (in_sew),
  .in_policy (in_policy),
  .in_data   (in_data),
  .sew_err   (sew_err),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/vil_layout_mapper_tb.sv
`timescale 1ns/1ps
module vil_layout_mapper_tb;

  localparam int VLEN = 128;
  localparam int SLEN = 32;
  localparam int NB   = VLEN / 8;
  localparam int CB   = SLEN / 8;
  localparam int NCH  = VLEN / SLEN;
  localparam int HB   = CB / 2;
  localparam int FW   = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_dir = 1'b0, in_policy = 1'b0;
  logic [1:0] in_mode = 2'd0, in_sew = 2'd0;
  logic [VLEN-1:0] in_data = '0, in_old = '0;
  logic out_valid, out_err, f_valid, f_err;
  logic [VLEN-1:0] out_data;
  logic [FW-1:0] f_data;

  always #4 clk = ~clk; // 125 MHz

  vil_layout_mapper #(.VLEN(VLEN), .SLEN(SLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dir(in_dir),
    .in_mode(in_mode), .in_sew(in_sew), .in_policy(in_policy),
    .in_data(in_data), .in_old(in_old),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err));

  // chunk width equal to register width (R11)
  vil_layout_mapper #(.VLEN(FW), .SLEN(FW)) u_dut_flat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dir(in_dir),
    .in_mode(in_mode), .in_sew(in_sew), .in_policy(in_policy),
    .in_data(in_data[FW-1:0]), .in_old(in_old[FW-1:0]),
    .out_valid(f_valid), .out_data(f_data), .out_err(f_err));

  typedef struct {
    logic [VLEN-1:0] data;
    logic            err;
    logic            chk_flat;
    logic [FW-1:0]   flat;
    int              req;
    int              cyc;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference layout, written element by element
  function automatic logic [VLEN-1:0] model(logic dir, logic [1:0] mode, logic [1:0] sew,
                                            logic pol, logic [VLEN-1:0] d,
                                            logic [VLEN-1:0] old, output logic err);
    logic [VLEN-1:0] r;
    int eb, m;
    eb  = 1 << sew;
    err = (eb * 8) > SLEN;
    m   = err ? 3 : int'(mode);
    r   = '0;
    if (m == 3) r = d;
    else if (m == 0) begin
      for (int i = 0; i < NB / eb; i++)
        for (int b = 0; b < eb; b++) begin
          int rb, mb;
          rb = (i % NCH) * CB + (i / NCH) * eb + b;
          mb = i * eb + b;
          if (!dir) r[8*rb +: 8] = d[8*mb +: 8];
          else      r[8*mb +: 8] = d[8*rb +: 8];
        end
    end else begin
      int off;
      off = (m == 2) ? HB : 0;
      if (!dir) r = pol ? '1 : old;
      for (int k = 0; k < NB / 2; k++) begin
        int rb;
        rb = (k / HB) * CB + off + (k % HB);
        if (!dir) r[8*rb +: 8] = d[8*k +: 8];
        else      r[8*k +: 8]  = d[8*rb +: 8];
      end
    end
    return r;
  endfunction

  function automatic logic [VLEN-1:0] pat(int seed);
    logic [VLEN-1:0] r;
    for (int k = 0; k < NB; k++) r[8*k +: 8] = 8'(seed * 29 + k * 7 + 1);
    return r;
  endfunction

  task automatic check(bit ok, int req, string what, logic [VLEN-1:0] act, logic [VLEN-1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic send(int req, logic dir, logic [1:0] mode, logic [1:0] sew, logic pol,
                      logic [VLEN-1:0] d, logic [VLEN-1:0] old);
    exp_t e;
    logic er;
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_mode = mode; in_sew = sew;
    in_policy = pol; in_data = d; in_old = old;
    e.data     = model(dir, mode, sew, pol, d, old, er);
    e.err      = er;
    e.chk_flat = (mode == 2'd0 || mode == 2'd3);
    e.flat     = d[FW-1:0];
    e.req      = req;
    e.cyc      = cyc;
    q.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q.size() == 0) check(1'b0, 2, "unexpected out_valid", '0, '0);
        else begin
          exp_t e;
          e = q.pop_front();
          check(out_data === e.data, e.req, "out_data", out_data, e.data);
          check(out_err === e.err, 10, "out_err", VLEN'(out_err), VLEN'(e.err));
          if (e.chk_flat) // R11: round-robin equals flat when SLEN == VLEN
            check(f_valid && f_data === e.flat, 11, "flat instance", VLEN'(f_data), VLEN'(e.flat));
        end
      end else if (q.size() > 0 && q[0].cyc < cyc) begin
        check(1'b0, 2, "missing out_valid", '0, VLEN'(1));
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(out_valid === 1'b0 && out_err === 1'b0 && out_data === '0, 1, "reset state",
          out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_data === '0 && f_valid === 1'b0, 1, "after reset",
          out_data, '0);

    // back-to-back stream (R2)
    send(3, 1'b0, 2'd3, 2'd0, 1'b0, pat(1), pat(2));   // R3 flat load
    send(3, 1'b1, 2'd3, 2'd2, 1'b0, pat(3), pat(4));   // R3 flat store
    send(4, 1'b0, 2'd0, 2'd0, 1'b0, pat(5), pat(6));   // R4 bytes
    send(4, 1'b0, 2'd0, 2'd1, 1'b0, pat(7), pat(8));   // R4 halfwords
    send(4, 1'b0, 2'd0, 2'd2, 1'b0, pat(9), pat(10));  // R4 one slot per chunk
    send(5, 1'b1, 2'd0, 2'd0, 1'b0, pat(11), pat(12)); // R5 bytes
    send(5, 1'b1, 2'd0, 2'd1, 1'b0, pat(13), pat(14)); // R5 halfwords
    send(6, 1'b0, 2'd1, 2'd0, 1'b0, pat(15), pat(16)); // R6 with R8 undisturbed
    send(6, 1'b0, 2'd1, 2'd1, 1'b1, pat(17), pat(18)); // R6 with R8 agnostic
    send(7, 1'b0, 2'd2, 2'd0, 1'b0, pat(19), pat(20)); // R7 with R8 undisturbed
    send(7, 1'b0, 2'd2, 2'd0, 1'b1, pat(21), pat(22)); // R7 with R8 agnostic
    @(negedge clk); in_valid = 1'b0;                   // gap cycle, R2 idle
    send(8, 1'b0, 2'd1, 2'd0, 1'b0, '0, '1);           // R8 old all ones kept
    send(9, 1'b1, 2'd1, 2'd0, 1'b0, pat(23), pat(24)); // R9 lower gather
    send(9, 1'b1, 2'd2, 2'd1, 1'b0, pat(25), pat(26)); // R9 upper gather
    send(10, 1'b0, 2'd0, 2'd3, 1'b0, pat(27), pat(28)); // R10 wide SEW load
    send(10, 1'b1, 2'd2, 2'd3, 1'b1, pat(29), pat(30)); // R10 wide SEW store
    send(11, 1'b0, 2'd0, 2'd3, 1'b0, pat(31), pat(32)); // R11 wide element
    send(11, 1'b1, 2'd0, 2'd1, 1'b0, pat(33), pat(34)); // R11 store
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(q.size() == 0, 2, "results outstanding", VLEN'(q.size()), '0);
    done = 1;
    finish_run();
  end

endmodule